// File: doc/BRIEF.md
# Byte-Zone Read Data Steering

This block sits on the read side between a memory word and an active-low parallel bus. Each word has two byte zones: zone 1 is the low byte of the word and zone 2 is the high byte. A bus master opens a read by pulling its strobe low. At that moment the block latches a small command: whether the master asked for a byte (active-low byte request) and the lowest address bit. The command stays fixed until the strobe is released.

When the memory reports that its word is valid, the block captures the word. It raises the driver enables that the command selects and presents the data on the bus, inverted. A word read drives both zones on their own lanes. A byte read drives only one zone, and always on the low eight lanes. When address bit 0 is low, the zone 2 byte is shifted down onto those lanes. One cycle after the data appears, the block pulls its active-low done. Releasing the strobe returns every output to idle.

Top module: `rd_zone_steer`

## Requirements
- R1: During and right after reset, both zone enables are low, `done_n` is high and `bus_data_n` is all ones.
- R2: The byte request and address bit 0 are captured on the first clock edge that samples `stb_n` low after it was high. Changes on `byte_n` or `addr0` after that edge have no effect on the cycle in progress.
- R3: A word read (`byte_n` high at capture) raises both `zone1_en` and `zone2_en`. `bus_data_n` equals the inverted memory word: zone 1 (bits 7:0) on lanes 7:0 and zone 2 (bits 15:8) on lanes 15:8.
- R4: A byte read with address bit 0 high raises only `zone1_en`. Lanes 7:0 carry the inverted word bits 7:0 and lanes 15:8 are all ones.
- R5: A byte read with address bit 0 low raises only `zone2_en`. Lanes 7:0 carry the inverted word bits 15:8 and lanes 15:8 are all ones.
- R6: The enables and the bus data appear one edge after an edge that samples `mem_valid` high with the cycle open and the strobe low. The word captured at that edge is held, even if `mem_word` later changes. While `mem_valid` stays low, no enable rises.
- R7: `done_n` goes low exactly one cycle after the enables rise. It stays low while the strobe is held.
- R8: An edge that samples `stb_n` high clears both enables, sets `done_n` high and sets `bus_data_n` to all ones. This holds even when the strobe is released before the memory data arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_n | input | 1 | Active-low read strobe from the master |
| byte_n | input | 1 | Active-low byte request |
| addr0 | input | 1 | Address bit 0, high selects zone 1 |
| mem_valid | input | 1 | Memory word is valid |
| mem_word | input | 16 | Word read from memory |
| zone1_en | output | 1 | Zone 1 driver enable |
| zone2_en | output | 1 | Zone 2 driver enable |
| done_n | output | 1 | Active-low cycle done |
| bus_data_n | output | 16 | Active-low bus data lanes |

## Verification
The command is latched on the edge that sees the strobe fall. The enables and bus data follow one edge after `mem_valid` is seen, and `done_n` falls one edge after that. A strobe release shows at the outputs one edge after it is sampled. The bench drives inputs two nanoseconds after a rising edge and reads the outputs in that same quiet window, one edge after each stimulus. It checks each result in the exact cycle it is due, and also checks that it has not appeared one cycle early. To test the R2 and R6 hold behaviour, the bench flips the command inputs and the memory word after capture and before the outputs are sampled.

// File: rtl/rd_zone_pkg.sv
package rd_zone_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_DONE  = 2'd3
  } rd_state_e;

  typedef struct packed {
    logic byte_req;
    logic addr_lo;
  } rd_cmd_t;
endpackage

// File: rtl/rd_cmd_reg.sv
module rd_cmd_reg
  import rd_zone_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    load,
  input  logic    byte_n,
  input  logic    addr0,
  output rd_cmd_t cmd
);
  rd_cmd_t cmd_d, cmd_q;

  always_comb begin
    cmd_d = cmd_q;
    if (load) begin
      cmd_d.byte_req = ~byte_n;
      cmd_d.addr_lo  = addr0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end

  assign cmd = cmd_q;
endmodule

// File: rtl/rd_seq.sv
module rd_seq
  import rd_zone_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb_n,
  input  logic mem_valid,
  output logic load_cmd,
  output logic cap_data,
  output logic drive,
  output logic done_n
);
  rd_state_e state_q, state_d;
  logic      stb_prev_q;

  assign load_cmd = (state_q == ST_IDLE) && stb_prev_q && !stb_n;
  assign cap_data = (state_q == ST_WAIT) && !stb_n && mem_valid;

  always_comb begin
    state_d = state_q;
    if (stb_n) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (load_cmd) state_d = ST_WAIT;
        ST_WAIT:  if (cap_data) state_d = ST_DRIVE;
        ST_DRIVE: state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      stb_prev_q <= 1'b1;
    end else begin
      state_q    <= state_d;
      stb_prev_q <= stb_n;
    end
  end

  assign drive  = (state_q == ST_DRIVE) || (state_q == ST_DONE);
  assign done_n = (state_q != ST_DONE);
endmodule

// File: rtl/rd_lane_mux.sv
module rd_lane_mux
  import rd_zone_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_data,
  input  logic [DATA_W-1:0] mem_word,
  input  logic              drive,
  input  rd_cmd_t           cmd,
  output logic              lo_en,
  output logic              hi_en,
  output logic [DATA_W-1:0] bus_data_n
);
  localparam int ZONE_W = DATA_W / 2;

  logic [DATA_W-1:0] word_d, word_q;
  logic              shift_down;

  always_comb begin
    word_d = word_q;
    if (cap_data) word_d = mem_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign lo_en      = drive && (!cmd.byte_req || cmd.addr_lo);
  assign hi_en      = drive && (!cmd.byte_req || !cmd.addr_lo);
  assign shift_down = hi_en && cmd.byte_req;

  for (genvar i = 0; i < ZONE_W; i++) begin : g_lane
    logic lo_bit, hi_bit;
    always_comb begin
      lo_bit = 1'b0;
      if (lo_en)           lo_bit = word_q[i];
      else if (shift_down) lo_bit = word_q[ZONE_W+i];
      hi_bit = (hi_en && !cmd.byte_req) ? word_q[ZONE_W+i] : 1'b0;
    end
    assign bus_data_n[i]        = ~lo_bit;
    assign bus_data_n[ZONE_W+i] = ~hi_bit;
  end
endmodule

// File: rtl/rd_zone_steer.sv
module rd_zone_steer
  import rd_zone_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb_n,
  input  logic              byte_n,
  input  logic              addr0,
  input  logic              mem_valid,
  input  logic [DATA_W-1:0] mem_word,
  output logic              zone1_en,
  output logic              zone2_en,
  output logic              done_n,
  output logic [DATA_W-1:0] bus_data_n
);
  logic    load_cmd, cap_data, drive;
  rd_cmd_t cmd;

  rd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .mem_valid(mem_valid),
    .load_cmd(load_cmd), .cap_data(cap_data), .drive(drive), .done_n(done_n)
  );

  rd_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .load(load_cmd),
    .byte_n(byte_n), .addr0(addr0), .cmd(cmd)
  );

  rd_lane_mux #(.DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .cap_data(cap_data), .mem_word(mem_word),
    .drive(drive), .cmd(cmd), .lo_en(zone1_en), .hi_en(zone2_en),
    .bus_data_n(bus_data_n)
  );
endmodule

// File: rtl/rd_zone_steer_chk.sv
module rd_zone_steer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stb_n,
  input logic              mem_valid,
  input logic              zone1_en,
  input logic              zone2_en,
  input logic              done_n,
  input logic [DATA_W-1:0] bus_data_n
);
  localparam int ZONE_W = DATA_W / 2;

  a_r7_done_after_en: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_n) |-> $past(zone1_en || zone2_en));

  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stb_n |=> (!zone1_en && !zone2_en && done_n && (&bus_data_n)));

  a_r6_en_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zone1_en || zone2_en) |-> ($past(mem_valid) && !$past(stb_n)));

  a_r5_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (zone1_en ^ zone2_en) |-> (&bus_data_n[DATA_W-1:ZONE_W]));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((zone1_en || zone2_en) && !stb_n) |=>
      ($stable(bus_data_n) && $stable(zone1_en) && $stable(zone2_en)));
endmodule

bind rd_zone_steer rd_zone_steer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .mem_valid(mem_valid),
  .zone1_en(zone1_en), .zone2_en(zone2_en), .done_n(done_n),
  .bus_data_n(bus_data_n)
);

// File: tb/rd_zone_steer_test.sv
module rd_zone_steer_test;
  logic        clk = 1'b0;
  logic        rst_n, stb_n, byte_n, addr0, mem_valid;
  logic [15:0] mem_word;
  logic        zone1_en, zone2_en, done_n;
  logic [15:0] bus_data_n;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  rd_zone_steer uut (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .byte_n(byte_n), .addr0(addr0),
    .mem_valid(mem_valid), .mem_word(mem_word), .zone1_en(zone1_en),
    .zone2_en(zone2_en), .done_n(done_n), .bus_data_n(bus_data_n)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [18:0] act, logic [18:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [18:0] outs();
    return {zone1_en, zone2_en, done_n, bus_data_n};
  endfunction

  localparam logic [18:0] IDLE_O = {1'b0, 1'b0, 1'b1, 16'hFFFF};

  // one read: byte request, addr0, word, expected enables and bus
  task automatic do_read(string req, logic bn, logic a0, logic [15:0] w,
                         logic e1, logic e2, logic [15:0] ebus);
    byte_n = bn; addr0 = a0; stb_n = 1'b0; mem_valid = 1'b0;
    tick();                       // capture edge (R2)
    chk({req, " R2 capture idle"}, outs(), IDLE_O);
    byte_n = ~bn; addr0 = ~a0;    // R2: late changes ignored
    mem_word = w; mem_valid = 1'b1;
    tick();                       // data edge (R6)
    chk({req, " R6 data"}, outs(), {e1, e2, 1'b1, ebus});
    mem_valid = 1'b0; mem_word = ~w;
    tick();
    chk({req, " R7 done"}, outs(), {e1, e2, 1'b0, ebus});
    tick();
    chk({req, " R2 hold"}, outs(), {e1, e2, 1'b0, ebus});
    stb_n = 1'b1;
    tick();
    chk({req, " R8 release"}, outs(), IDLE_O);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stb_n = 1'b1; byte_n = 1'b1; addr0 = 1'b0;
    mem_valid = 1'b0; mem_word = 16'h0000;
    tick(); tick();
    chk("R1 in reset", outs(), IDLE_O);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", outs(), IDLE_O);
  endtask

  task automatic t_late_valid();
    byte_n = 1'b1; addr0 = 1'b0; stb_n = 1'b0; mem_valid = 1'b0;
    mem_word = 16'h5AC3;
    tick(); tick(); tick();
    chk("R6 no valid no enable", outs(), IDLE_O);
    mem_valid = 1'b1;
    tick();
    chk("R6 late valid", outs(), {1'b1, 1'b1, 1'b1, ~16'h5AC3});
    mem_valid = 1'b0;
    tick();
    chk("R7 late done", outs(), {1'b1, 1'b1, 1'b0, ~16'h5AC3});
    stb_n = 1'b1;
    tick();
    chk("R8 late release", outs(), IDLE_O);
  endtask

  task automatic t_abort();
    byte_n = 1'b0; addr0 = 1'b1; stb_n = 1'b0; mem_valid = 1'b0;
    tick();
    stb_n = 1'b1; mem_valid = 1'b1; mem_word = 16'h1234;
    tick();
    chk("R8 abort", outs(), IDLE_O);
    tick();
    chk("R8 abort stays idle", outs(), IDLE_O);
    mem_valid = 1'b0;
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    do_read("R3 word", 1'b1, 1'b0, 16'hA55A, 1'b1, 1'b1, ~16'hA55A);
    do_read("R3 word b", 1'b1, 1'b1, 16'h0FF0, 1'b1, 1'b1, ~16'h0FF0);
    do_read("R4 zone1", 1'b0, 1'b1, 16'hC33C, 1'b1, 1'b0, {8'hFF, ~8'h3C});
    do_read("R5 zone2", 1'b0, 1'b0, 16'hC33C, 1'b0, 1'b1, {8'hFF, ~8'hC3});
    do_read("R5 zone2 b", 1'b0, 1'b0, 16'h81FE, 1'b0, 1'b1, {8'hFF, ~8'h81});
    t_late_valid();
    t_abort();
    do_read("R4 zone1 b", 1'b0, 1'b1, 16'h7E01, 1'b1, 1'b0, {8'hFF, ~8'h01});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule